// File: doc/BRIEF.md
# Serial Interface Halt Sequencer

This block moves a two-mode serial interface into and out of a low-power halt state when a system-level stop request arrives. The interface runs either as a plain asynchronous character link or as a LIN frame engine, and the path into halt differs between them. In character mode the sequencer simply waits until both engines are quiet. In LIN mode it lets an outgoing byte finish, cuts an incoming byte off at once, and returns the LIN protocol logic to idle before halting.

The transmit and receive engines and the register file sit outside this block. They report busy and end-of-byte status, and they take back single-cycle control pulses: receive abort, protocol engine reset, write-counter clear, and the two ready-flag set strobes. A level output tells the transmitter to wind down and hold off its flags. A second level reports that the interface is halted. All outputs are registered. The inputs are sampled on the rising clock edge, and their effect shows on the outputs after that same edge.

Top module: `sci_halt_ctrl`

## Requirements
- R1: In character mode (`lin_sel`=0), `halted` rises one cycle after a cycle with `stop_req`=1 and both `tx_busy` and `rx_busy` at 0. While either busy input is 1, `halted` stays 0.
- R2: From halt, a cycle with `stop_req`=0, `mod_dis`=0 and `lin_sel`=0 makes `halted` fall and `set_tdre` pulse, both after the next edge.
- R3: From halt, a cycle with `stop_req`=0, `mod_dis`=0 and `lin_sel`=1 makes `halted` fall and `set_txrdy` pulse, both after the next edge.
- R4: In LIN mode, `stop_req`=1 while `tx_busy`=1 raises `tx_wind_down` on the next cycle. It stays high, with `halted` at 0, until the cycle after `tx_byte_end`=1 is seen.
- R5: When a wind-down ends, `halted` rises and `lin_eng_rst` and `wcnt_clr` each pulse in that same cycle. Neither ready-flag strobe fires during the wind-down.
- R6: In LIN mode, `stop_req`=1 while `rx_busy`=1 pulses `rx_abort` on the next cycle. This happens even while a transmit wind-down starts in parallel.
- R7: In LIN mode, `stop_req`=1 with no transmission running makes `halted` rise, with a `lin_eng_rst` and `wcnt_clr` pulse in the same cycle.
- R8: While `mod_dis`=1, a halted controller stays halted whatever `stop_req` does.
- R9: If `stop_req` falls during a wind-down, the controller still finishes the wind-down and stays halted for at least one cycle before any exit strobe.
- R10: Every strobe output is high for one cycle only. `halted` and `tx_wind_down` are levels, and the two ready strobes never fire together.
- R11: A synchronous active-high `rst` puts the controller in the running state with every output at 0.
- R12: Entering halt never fires `set_tdre` or `set_txrdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | System stop request |
| lin_sel | input | 1 | 1 selects LIN frame mode, 0 selects character mode |
| mod_dis | input | 1 | Module disable; keeps a halted controller halted |
| tx_busy | input | 1 | Transmit engine is sending a byte |
| rx_busy | input | 1 | Receive engine is taking in a byte |
| tx_byte_end | input | 1 | Last bit of the current transmit byte is done |
| halted | output | 1 | Level: interface is in halt |
| tx_wind_down | output | 1 | Level: finish current byte, drop pending requests, suppress transmit flags |
| rx_abort | output | 1 | Pulse: abandon current reception without flags |
| lin_eng_rst | output | 1 | Pulse: return LIN protocol engine to idle |
| wcnt_clr | output | 1 | Pulse: clear LIN transmit write-access counter |
| set_tdre | output | 1 | Pulse: set transmit-data-empty flag |
| set_txrdy | output | 1 | Pulse: set LIN transmit-ready flag |

## Verification
A corrupted state register shows at the ports within one cycle. `halted` and `tx_wind_down` decode the state directly, so a wrong state makes them disagree with what the stimulus has driven. A transition that is missed or misrouted shows up on the edge that follows the triggering input. Examples are a halt taken while busy, a wind-down that never ends, or the wrong ready strobe on exit. The bench therefore compares every output on every cycle of its vector walk. A wind-down that lasts too long, or a halt that is skipped before exit, appears as a one-cycle shift in the strobe pattern.

// File: rtl/sci_halt_pkg.sv
package sci_halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } halt_state_e;

  typedef struct packed {
    logic char_enter;
    logic lin_enter_now;
    logic lin_enter_drain;
    logic lin_rx_kill;
    logic exit_ok;
  } halt_dec_t;
endpackage

// File: rtl/sci_halt_cond.sv
module sci_halt_cond
  import sci_halt_pkg::*;
(
  input  logic      stop_req,
  input  logic      lin_sel,
  input  logic      mod_dis,
  input  logic      tx_busy,
  input  logic      rx_busy,
  output halt_dec_t dec
);
  always_comb begin
    dec.char_enter      = stop_req && !lin_sel && !tx_busy && !rx_busy;
    dec.lin_enter_now   = stop_req && lin_sel && !tx_busy;
    dec.lin_enter_drain = stop_req && lin_sel && tx_busy;
    dec.lin_rx_kill     = stop_req && lin_sel && rx_busy;
    dec.exit_ok         = !stop_req && !mod_dis;
  end
endmodule

// File: rtl/sci_halt_fsm.sv
module sci_halt_fsm
  import sci_halt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  halt_dec_t dec,
  input  logic      lin_sel,
  input  logic      mod_dis,
  input  logic      tx_busy,
  input  logic      rx_busy,
  input  logic      stop_req,
  input  logic      tx_byte_end,
  output logic      halted,
  output logic      tx_wind_down,
  output logic      rx_abort,
  output logic      lin_eng_rst,
  output logic      wcnt_clr,
  output logic      set_tdre,
  output logic      set_txrdy
);
  halt_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      rx_abort    <= 1'b0;
      lin_eng_rst <= 1'b0;
      wcnt_clr    <= 1'b0;
      set_tdre    <= 1'b0;
      set_txrdy   <= 1'b0;
    end else begin
      rx_abort    <= 1'b0;
      lin_eng_rst <= 1'b0;
      wcnt_clr    <= 1'b0;
      set_tdre    <= 1'b0;
      set_txrdy   <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (dec.lin_rx_kill) rx_abort <= 1'b1;
          if (dec.char_enter) begin
            state <= ST_HALT;
          end else if (dec.lin_enter_drain) begin
            state <= ST_DRAIN;
          end else if (dec.lin_enter_now) begin
            state       <= ST_HALT;
            lin_eng_rst <= 1'b1;
            wcnt_clr    <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (tx_byte_end) begin
            state       <= ST_HALT;
            lin_eng_rst <= 1'b1;
            wcnt_clr    <= 1'b1;
          end
        end
        ST_HALT: begin
          if (dec.exit_ok) begin
            state     <= ST_RUN;
            set_txrdy <= lin_sel;
            set_tdre  <= !lin_sel;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign halted       = (state == ST_HALT);
  assign tx_wind_down = (state == ST_DRAIN);

  // R1: character mode never halts while an engine is busy
  a_r1_char_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && stop_req && !lin_sel && (tx_busy || rx_busy)) |=> !halted);
  // R4: wind-down holds off halt until the byte ends
  a_r4_drain_waits: assert property (@(posedge clk) disable iff (rst)
    (tx_wind_down && !tx_byte_end) |=> (tx_wind_down && !halted));
  // R5: the end of a wind-down brings the LIN cleanup strobes
  a_r5_drain_cleanup: assert property (@(posedge clk) disable iff (rst)
    (tx_wind_down && tx_byte_end) |=> (halted && lin_eng_rst && wcnt_clr));
  // R8: disable keeps the controller halted
  a_r8_disable_hold: assert property (@(posedge clk) disable iff (rst)
    (halted && mod_dis) |=> halted);
  // R10: strobes last one cycle, ready strobes are exclusive
  a_r10_tdre_single: assert property (@(posedge clk) disable iff (rst)
    set_tdre |=> !set_tdre);
  a_r10_txrdy_single: assert property (@(posedge clk) disable iff (rst)
    set_txrdy |=> !set_txrdy);
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_tdre, set_txrdy}));
  // R12: ready strobes only come with leaving halt
  a_r12_ready_on_exit: assert property (@(posedge clk) disable iff (rst)
    (set_tdre || set_txrdy) |-> (!halted && $past(halted)));
endmodule

// File: rtl/sci_halt_ctrl.sv
module sci_halt_ctrl
  import sci_halt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic lin_sel,
  input  logic mod_dis,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic tx_byte_end,
  output logic halted,
  output logic tx_wind_down,
  output logic rx_abort,
  output logic lin_eng_rst,
  output logic wcnt_clr,
  output logic set_tdre,
  output logic set_txrdy
);
  halt_dec_t dec;

  sci_halt_cond u_cond (
    .stop_req (stop_req),
    .lin_sel  (lin_sel),
    .mod_dis  (mod_dis),
    .tx_busy  (tx_busy),
    .rx_busy  (rx_busy),
    .dec      (dec)
  );

  sci_halt_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .dec          (dec),
    .lin_sel      (lin_sel),
    .mod_dis      (mod_dis),
    .tx_busy      (tx_busy),
    .rx_busy      (rx_busy),
    .stop_req     (stop_req),
    .tx_byte_end  (tx_byte_end),
    .halted       (halted),
    .tx_wind_down (tx_wind_down),
    .rx_abort     (rx_abort),
    .lin_eng_rst  (lin_eng_rst),
    .wcnt_clr     (wcnt_clr),
    .set_tdre     (set_tdre),
    .set_txrdy    (set_txrdy)
  );

  // R6: a LIN stop during reception aborts it on the next cycle
  a_r6_rx_kill: assert property (@(posedge clk) disable iff (rst)
    (!halted && !tx_wind_down && stop_req && lin_sel && rx_busy) |=> rx_abort);
  // R11: first cycle after reset is running with strobes low
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (!halted && !tx_wind_down && !rx_abort && !set_tdre && !set_txrdy));
endmodule

// File: tb/sci_halt_ctrl_bench.sv
module sci_halt_ctrl_bench;
  logic clk = 1'b0;
  logic rst, stop_req, lin_sel, mod_dis, tx_busy, rx_busy, tx_byte_end;
  logic halted, tx_wind_down, rx_abort, lin_eng_rst, wcnt_clr, set_tdre, set_txrdy;
  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sci_halt_ctrl u_sci_halt_ctrl (
    .clk(clk), .rst(rst), .stop_req(stop_req), .lin_sel(lin_sel), .mod_dis(mod_dis),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_byte_end(tx_byte_end),
    .halted(halted), .tx_wind_down(tx_wind_down), .rx_abort(rx_abort),
    .lin_eng_rst(lin_eng_rst), .wcnt_clr(wcnt_clr), .set_tdre(set_tdre), .set_txrdy(set_txrdy)
  );

  // {stop,lin,dis,txb,rxb,end} , {halted,wind,rxab,leng,wclr,tdre,txrdy}
  localparam int NV = 29;
  localparam logic [12:0] VEC [NV] = '{
    13'b000000_0000000, // R11 idle running
    13'b100100_0000000, // R1 char stop, tx busy
    13'b100010_0000000, // R1 char stop, rx busy
    13'b100000_1000000, // R1 char stop idle -> halt
    13'b100000_1000000, // R12 no strobe while halted
    13'b000000_0000010, // R2 exit char, tdre
    13'b000000_0000000, // R10 strobe one cycle
    13'b110100_0100000, // R4 LIN stop tx busy -> wind down
    13'b110100_0100000, // R4 still winding
    13'b110101_1001100, // R5 byte end -> halt + cleanup
    13'b110000_1000000, // R10 cleanup strobes one cycle
    13'b010000_0000001, // R3 exit LIN, txrdy
    13'b010000_0000000, // R10
    13'b110010_1011100, // R6 R7 LIN stop rx busy, tx idle
    13'b011000_1000000, // R8 disabled hold
    13'b001000_1000000, // R8 disabled hold
    13'b010000_0000001, // R3 exit LIN
    13'b110000_1001100, // R7 LIN stop idle
    13'b000000_0000010, // R2 exit char after LIN halt
    13'b110100_0100000, // R4 wind down
    13'b010100_0100000, // R9 stop dropped mid wind-down
    13'b010001_1001100, // R9 wind-down completes -> halt
    13'b010000_0000001, // R9 exit only after a halted cycle
    13'b010000_0000000, // R10
    13'b110110_0110000, // R6 abort alongside wind-down
    13'b110110_0100000, // R10 abort single pulse
    13'b110001_1001100, // R5 byte end
    13'b100000_1000000, // R12 halted, mode flip ignored while stopped
    13'b000000_0000010  // R2 exit char
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R11"; 1, 2, 3: return "R1"; 4, 27: return "R12";
      5, 18, 28: return "R2"; 11, 16: return "R3"; 7, 8, 19: return "R4";
      9, 26: return "R5"; 13, 24: return "R6"; 17: return "R7";
      14, 15: return "R8"; 20, 21, 22: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [6:0] outs();
    return {halted, tx_wind_down, rx_abort, lin_eng_rst, wcnt_clr, set_tdre, set_txrdy};
  endfunction

  task automatic check(string tag, logic [6:0] exp);
    n_vec++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic drive(logic [5:0] v);
    {stop_req, lin_sel, mod_dis, tx_busy, rx_busy, tx_byte_end} = v;
  endtask

  initial begin
    rst = 1'b1;
    drive(6'b0);
    repeat (2) @(posedge clk);
    #1;
    check("R11", 7'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:7]);
      @(posedge clk);
      #1;
      check(tag_of(i), VEC[i][6:0]);
    end
    // R11: reset in the middle of a wind-down
    drive(6'b110100);
    @(posedge clk); #1;
    check("R4", 7'b0100000);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11", 7'b0);
    rst = 1'b0;
    drive(6'b100000);
    @(posedge clk); #1;
    check("R1", 7'b1000000);
    // R8: disabled, stop toggling does not release halt
    drive(6'b101000);
    @(posedge clk); #1;
    check("R8", 7'b1000000);
    drive(6'b001000);
    @(posedge clk); #1;
    check("R8", 7'b1000000);
    drive(6'b000000);
    @(posedge clk); #1;
    check("R2", 7'b0000010);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: outputs %b expected completion", outs());
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule